// File: doc/BRIEF.md
# Partition power-up sequencer

This block brings one power partition out of the off state in a fixed, safe order and takes it back down if any step goes wrong. A single-cycle start pulse names the partition. The block holds that partition in reset and stops its clock. It asks for power unless the partition already reports powered. It then enables the clock, waits a fixed settling time, releases the isolation clamps and finally lets go of reset. Every wait on a status input is a bounded poll on a microsecond tick. The tick comes from a clock-cycles-per-microsecond parameter.

The block ends each sequence with a one-cycle done pulse or a one-cycle error pulse. The error code tells which step failed. Before it raises the error, the block unwinds the steps already taken, and the unwind path depends on how far the sequence got. Two partitions form a crossed pair: the clamp command bit of each is the other's index. One graphics partition has its clamps released by a dedicated write strobe instead of the command vector.

Top module: `part_pwrup_seq`

## Requirements
- R1: After reset, `rst_req_o` is 1, `clk_en_o` is 0, `busy_o` is 0 and no request, done or error pulse is raised.
- R2: A run holds reset and stops the clock before it requests power. The clock is enabled only after the partition reports powered, with reset still held. Clamp release happens while the clock runs and reset is held. Reset is released last, and `done_o` then pulses for one cycle with `rst_req_o` 0 and `clk_en_o` 1.
- R3: If `powered_i[id]` is already 1 when checked, no `pwr_on_o` pulse is issued and the run continues to clock enable.
- R4: The wait for powered polls once per microsecond, at most POLL_LIMIT times. The first poll falls CYC_PER_US cycles after the request. Power arriving by the last poll succeeds; otherwise the error code is 1.
- R5: With the clock acknowledge present at the first poll, the clamp release strobe comes exactly (1+SETTLE_US)*CYC_PER_US cycles after `clk_en_o` rises.
- R6: If `clk_ok_i` is not seen within POLL_LIMIT polls after clock enable, the error code is 2.
- R7: Clamp release drives `clamp_cmd_o` for one cycle with exactly one bit set, bit `id`, unless a swap or graphics rule applies. If `clamp_busy_i` stays 1 for POLL_LIMIT polls, the error code is 3.
- R8: For partition PAIR_A the command bit is PAIR_B, and the reverse. The clamp status is still read at the partition's own index.
- R9: If `clamped_i[id]` is still 1 once the command completes, the error code is 4.
- R10: For partition GFX_ID, `gfx_clamp_wr_o` pulses instead and `clamp_cmd_o` stays 0. No clamp completion or status wait follows.
- R11: If `part_rst_act_i` stays 1 for POLL_LIMIT polls after reset is released, the error code is 5.
- R12: On codes 1 and 2 the block reasserts reset and pulses `pwr_off_o`, with no clock change. On codes 3, 4 and 5 it first drops `clk_en_o`, then reasserts reset, then pulses `pwr_off_o`. `err_o` then pulses for one cycle with `err_code_o` valid, and the block returns to idle.
- R13: A start pulse while `busy_o` is 1 is ignored: the target partition and the outcome stay those of the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to start a sequence |
| part_id_i | input | PW | Target partition index, sampled with start_i |
| powered_i | input | N_PART | Per-partition powered status |
| clamped_i | input | N_PART | Per-partition clamp status (1 = still clamped) |
| clamp_busy_i | input | 1 | Clamp release command still in progress |
| clk_ok_i | input | 1 | Partition clock running acknowledge |
| part_rst_act_i | input | 1 | Partition reset still active |
| part_o | output | PW | Partition targeted by the current or last sequence |
| rst_req_o | output | 1 | Reset request toward the partition (1 = hold in reset) |
| clk_en_o | output | 1 | Clock enable request toward the partition |
| pwr_on_o | output | 1 | One-cycle power-on request |
| pwr_off_o | output | 1 | One-cycle power-off request |
| clamp_cmd_o | output | N_PART | One-cycle one-hot clamp release command |
| gfx_clamp_wr_o | output | 1 | One-cycle clamp release write for the graphics partition |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |
| err_code_o | output | 3 | Failed step: 1 power, 2 clock, 3 clamp timeout, 4 still clamped, 5 reset release |

## Verification
The assertions check ordering on every cycle: the power request only under reset with the clock stopped, clock enable only under reset, clamp release only with clock on and reset held, done only with the clock on and reset off, power-off only under reset, and a stable target while busy. Exact timing and decisions need the bench's scenarios: the settle interval in cycles, the last-poll boundary of the power wait, which error code each fault yields, the crossed clamp bits checked against own-index status, the graphics path and the unwind order.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

   typedef enum logic [4:0] {
      S_IDLE,
      S_RST_ON,
      S_CLK_OFF,
      S_PWR_CHK,
      S_PWR_REQ,
      S_PWR_WAIT,
      S_CLK_ON,
      S_CLK_WAIT,
      S_SETTLE,
      S_CLAMP_REQ,
      S_CLAMP_WAIT,
      S_RST_OFF,
      S_RST_WAIT,
      S_DONE,
      S_UNW_CLK,
      S_UNW_RST,
      S_UNW_PWR,
      S_FAIL
   } seq_state_e;

   typedef enum logic [2:0] {
      ERR_NONE     = 3'd0,
      ERR_PWR_TO   = 3'd1,
      ERR_CLK_TO   = 3'd2,
      ERR_CLAMP_TO = 3'd3,
      ERR_CLAMPED  = 3'd4,
      ERR_RST_TO   = 3'd5
   } seq_err_e;

endpackage

// File: rtl/pwrup_us_tick.sv
module pwrup_us_tick #(
   parameter int CYC_PER_US = 100
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   output logic tick_o
);
   localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (clr_i)           cnt_q <= '0;
      else if (cnt_q == LAST)   cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = (cnt_q == LAST);

   // R5
   tick_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST);
endmodule

// File: rtl/pwrup_poll_ctr.sv
module pwrup_poll_ctr #(
   parameter int POLL_LIMIT = 100,
   parameter int SETTLE_US  = 20
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic en_i,
   input  logic tick_i,
   output logic poll_last_o,
   output logic settle_last_o
);
   localparam int MAXV = (POLL_LIMIT > SETTLE_US) ? POLL_LIMIT : SETTLE_US;
   localparam int NW   = $clog2(MAXV + 1);

   logic [NW-1:0] n_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               n_q <= '0;
      else if (clr_i)            n_q <= '0;
      else if (en_i && tick_i)   n_q <= n_q + 1'b1;
   end

   assign poll_last_o   = (n_q == NW'(POLL_LIMIT - 1));
   assign settle_last_o = (n_q == NW'(SETTLE_US - 1));

   // R4
   poll_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      n_q < NW'(MAXV));
endmodule

// File: rtl/pwrup_clamp_map.sv
module pwrup_clamp_map #(
   parameter int N_PART = 8,
   parameter int PW     = 3,
   parameter int PAIR_A = 2,
   parameter int PAIR_B = 5,
   parameter int GFX_ID = 7
) (
   input  logic [PW-1:0]     part_i,
   output logic [N_PART-1:0] cmd_vec_o,
   output logic              gfx_o
);
   logic [PW-1:0] tgt;

   generate
      if (PAIR_A >= 0 && PAIR_B >= 0 && PAIR_A < N_PART && PAIR_B < N_PART) begin : g_swap
         always_comb begin
            if (part_i == PW'(PAIR_A))      tgt = PW'(PAIR_B);
            else if (part_i == PW'(PAIR_B)) tgt = PW'(PAIR_A);
            else                            tgt = part_i;
         end
      end else begin : g_noswap
         assign tgt = part_i;
      end

      if (GFX_ID >= 0 && GFX_ID < N_PART) begin : g_gfx
         assign gfx_o = (part_i == PW'(GFX_ID));
      end else begin : g_nogfx
         assign gfx_o = 1'b0;
      end

      for (genvar i = 0; i < N_PART; i++) begin : g_bit
         assign cmd_vec_o[i] = (tgt == PW'(i)) && !gfx_o;
      end
   endgenerate
endmodule

// File: rtl/part_pwrup_seq.sv
module part_pwrup_seq
   import pwrup_pkg::*;
#(
   parameter int N_PART     = 8,
   parameter int CYC_PER_US = 100,
   parameter int POLL_LIMIT = 100,
   parameter int SETTLE_US  = 20,
   parameter int PAIR_A     = 2,
   parameter int PAIR_B     = 5,
   parameter int GFX_ID     = 7,
   localparam int PW        = (N_PART > 1) ? $clog2(N_PART) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [PW-1:0]     part_id_i,
   input  logic [N_PART-1:0] powered_i,
   input  logic [N_PART-1:0] clamped_i,
   input  logic              clamp_busy_i,
   input  logic              clk_ok_i,
   input  logic              part_rst_act_i,
   output logic [PW-1:0]     part_o,
   output logic              rst_req_o,
   output logic              clk_en_o,
   output logic              pwr_on_o,
   output logic              pwr_off_o,
   output logic [N_PART-1:0] clamp_cmd_o,
   output logic              gfx_clamp_wr_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [2:0]        err_code_o
);
   generate
      if (CYC_PER_US < 1) begin : g_bad_cyc
         $error("CYC_PER_US must be at least 1");
      end
      if (POLL_LIMIT < 1 || SETTLE_US < 1) begin : g_bad_wait
         $error("POLL_LIMIT and SETTLE_US must be at least 1");
      end
      if (PAIR_A == PAIR_B && PAIR_A >= 0) begin : g_bad_pair
         $error("PAIR_A and PAIR_B must differ");
      end
   endgenerate

   seq_state_e state_q, state_d;
   seq_err_e   code_q, code_d;
   logic [PW-1:0] part_q;
   logic rst_q, clk_q;
   logic tick, poll_last, settle_last, cnt_en, chg;
   logic [N_PART-1:0] map_vec;
   logic is_gfx;

   assign chg    = (state_d != state_q);
   assign cnt_en = (state_q == S_PWR_WAIT) || (state_q == S_CLK_WAIT) ||
                   (state_q == S_SETTLE)   || (state_q == S_CLAMP_WAIT) ||
                   (state_q == S_RST_WAIT);

   pwrup_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(chg), .tick_o(tick));

   pwrup_poll_ctr #(.POLL_LIMIT(POLL_LIMIT), .SETTLE_US(SETTLE_US)) u_poll (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(chg), .en_i(cnt_en),
      .tick_i(tick), .poll_last_o(poll_last), .settle_last_o(settle_last));

   pwrup_clamp_map #(.N_PART(N_PART), .PW(PW), .PAIR_A(PAIR_A),
                     .PAIR_B(PAIR_B), .GFX_ID(GFX_ID)) u_map (
      .part_i(part_q), .cmd_vec_o(map_vec), .gfx_o(is_gfx));

   always_comb begin
      state_d = state_q;
      code_d  = code_q;
      unique case (state_q)
         S_IDLE:      if (start_i) begin state_d = S_RST_ON; code_d = ERR_NONE; end
         S_RST_ON:    state_d = S_CLK_OFF;
         S_CLK_OFF:   state_d = S_PWR_CHK;
         S_PWR_CHK:   state_d = powered_i[part_q] ? S_CLK_ON : S_PWR_REQ;
         S_PWR_REQ:   state_d = S_PWR_WAIT;
         S_PWR_WAIT:  if (tick) begin
                         if (powered_i[part_q]) state_d = S_CLK_ON;
                         else if (poll_last) begin state_d = S_UNW_RST; code_d = ERR_PWR_TO; end
                      end
         S_CLK_ON:    state_d = S_CLK_WAIT;
         S_CLK_WAIT:  if (tick) begin
                         if (clk_ok_i) state_d = S_SETTLE;
                         else if (poll_last) begin state_d = S_UNW_RST; code_d = ERR_CLK_TO; end
                      end
         S_SETTLE:    if (tick && settle_last) state_d = S_CLAMP_REQ;
         S_CLAMP_REQ: state_d = is_gfx ? S_RST_OFF : S_CLAMP_WAIT;
         S_CLAMP_WAIT: if (tick) begin
                         if (!clamp_busy_i) begin
                            if (clamped_i[part_q]) begin state_d = S_UNW_CLK; code_d = ERR_CLAMPED; end
                            else state_d = S_RST_OFF;
                         end else if (poll_last) begin
                            state_d = S_UNW_CLK; code_d = ERR_CLAMP_TO;
                         end
                      end
         S_RST_OFF:   state_d = S_RST_WAIT;
         S_RST_WAIT:  if (tick) begin
                         if (!part_rst_act_i) state_d = S_DONE;
                         else if (poll_last) begin state_d = S_UNW_CLK; code_d = ERR_RST_TO; end
                      end
         S_DONE:      state_d = S_IDLE;
         S_UNW_CLK:   state_d = S_UNW_RST;
         S_UNW_RST:   state_d = S_UNW_PWR;
         S_UNW_PWR:   state_d = S_FAIL;
         S_FAIL:      state_d = S_IDLE;
         default:     state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= S_IDLE;
         code_q  <= ERR_NONE;
         part_q  <= '0;
         rst_q   <= 1'b1;
         clk_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         code_q  <= code_d;
         if (state_q == S_IDLE && start_i) part_q <= part_id_i;
         if (state_q == S_RST_ON || state_q == S_UNW_RST) rst_q <= 1'b1;
         else if (state_q == S_RST_OFF)                   rst_q <= 1'b0;
         if (state_q == S_CLK_OFF || state_q == S_UNW_CLK) clk_q <= 1'b0;
         else if (state_q == S_CLK_ON)                     clk_q <= 1'b1;
      end
   end

   assign part_o         = part_q;
   assign rst_req_o      = rst_q;
   assign clk_en_o       = clk_q;
   assign pwr_on_o       = (state_q == S_PWR_REQ);
   assign pwr_off_o      = (state_q == S_UNW_PWR);
   assign clamp_cmd_o    = (state_q == S_CLAMP_REQ) ? map_vec : '0;
   assign gfx_clamp_wr_o = (state_q == S_CLAMP_REQ) && is_gfx;
   assign busy_o         = (state_q != S_IDLE);
   assign done_o         = (state_q == S_DONE);
   assign err_o          = (state_q == S_FAIL);
   assign err_code_o     = code_q;

   // R2
   pwr_req_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_on_o |-> (rst_req_o && !clk_en_o));
   // R2
   clk_rise_under_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_en_o) |-> rst_req_o);
   // R2
   rst_release_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rst_req_o) |-> clk_en_o);
   // R7
   clamp_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clamp_cmd_o != '0 || gfx_clamp_wr_o) |-> (clk_en_o && rst_req_o));
   // R7
   clamp_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(clamp_cmd_o) && !(gfx_clamp_wr_o && clamp_cmd_o != '0));
   // R2
   done_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!rst_req_o && clk_en_o && err_code_o == 3'd0));
   // R12
   unwind_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_off_o |-> rst_req_o);
   // R12
   err_code_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> (err_code_o != 3'd0 && err_code_o <= 3'd5));
   // R13
   start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i) |=> $stable(part_o));
endmodule

// File: tb/part_pwrup_seq_tb.sv
`timescale 1ns/1ps
module part_pwrup_seq_tb;
   localparam int N   = 8;
   localparam int PW  = 3;
   localparam int CYC = 4;
   localparam int LIM = 5;
   localparam int SET = 3;
   localparam int PA  = 2;
   localparam int PB  = 5;
   localparam int GFX = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic start = 1'b0;
   logic [PW-1:0] part_id = '0;
   logic [N-1:0] preset_pwr = '0;
   logic [N-1:0] powered_m;
   logic [N-1:0] clamped = '0;
   logic clamp_busy = 1'b0;
   logic clk_good = 1'b1;
   logic rst_stuck = 1'b0;
   logic clr_model = 1'b0;
   int   pwr_dly = 1;

   logic [PW-1:0] part_o;
   logic rst_req_o, clk_en_o, pwr_on_o, pwr_off_o, gfx_wr_o, busy_o, done_o, err_o;
   logic [N-1:0] clamp_cmd_o;
   logic [2:0] err_code_o;

   part_pwrup_seq #(.N_PART(N), .CYC_PER_US(CYC), .POLL_LIMIT(LIM), .SETTLE_US(SET),
                    .PAIR_A(PA), .PAIR_B(PB), .GFX_ID(GFX)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .part_id_i(part_id),
      .powered_i(powered_m | preset_pwr), .clamped_i(clamped),
      .clamp_busy_i(clamp_busy), .clk_ok_i(clk_en_o & clk_good),
      .part_rst_act_i(rst_req_o | rst_stuck), .part_o(part_o),
      .rst_req_o(rst_req_o), .clk_en_o(clk_en_o), .pwr_on_o(pwr_on_o),
      .pwr_off_o(pwr_off_o), .clamp_cmd_o(clamp_cmd_o), .gfx_clamp_wr_o(gfx_wr_o),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o));

   // partition model: powered pwr_dly cycles after the request (0 = never)
   logic pend;
   int   dcnt;
   always @(posedge clk) begin
      if (clr_model) begin
         powered_m <= '0; pend <= 1'b0; dcnt <= 0;
      end else begin
         if (pwr_on_o && pwr_dly != 0) begin
            if (pwr_dly == 1) powered_m[part_o] <= 1'b1;
            else begin pend <= 1'b1; dcnt <= 2; end
         end else if (pend) begin
            if (dcnt == pwr_dly) begin powered_m[part_o] <= 1'b1; pend <= 1'b0; end
            dcnt <= dcnt + 1;
         end
         if (pwr_off_o) powered_m[part_o] <= 1'b0;
      end
   end

   int checks = 0, errors = 0;
   int n_on, n_off, n_clamp, n_gfx, n_done, n_err, code_seen;
   int rise_c, fall_c, off_c, clamp_c, on_c, post_pulse;
   logic [N-1:0] clamp_seen;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_model();
      @(negedge clk); clr_model = 1'b1;
      @(negedge clk); clr_model = 1'b0;
   endtask

   task automatic run(input int p, input bit extra);
      logic prev_clk;
      bit fin;
      n_on = 0; n_off = 0; n_clamp = 0; n_gfx = 0; n_done = 0; n_err = 0;
      code_seen = -1; rise_c = -1; fall_c = -1; off_c = -1; clamp_c = -1; on_c = -1;
      clamp_seen = '0; fin = 0;
      @(negedge clk);
      prev_clk = clk_en_o;
      part_id = PW'(p); start = 1'b1;
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         if (c == 0) start = 1'b0;
         if (extra && c == 10) begin start = 1'b1; part_id = PW'(p ^ 1); end
         if (extra && c == 11) start = 1'b0;
         if (pwr_on_o) begin n_on++; on_c = c; end
         if (pwr_off_o) begin n_off++; off_c = c; end
         if (clk_en_o && !prev_clk) rise_c = c;
         if (!clk_en_o && prev_clk) fall_c = c;
         prev_clk = clk_en_o;
         if (clamp_cmd_o != '0) begin n_clamp++; clamp_seen = clamp_cmd_o; clamp_c = c; end
         if (gfx_wr_o) begin n_gfx++; clamp_c = c; end
         if (done_o) n_done++;
         if (err_o) begin n_err++; code_seen = int'(err_code_o); end
         if (done_o || err_o) begin fin = 1; break; end
      end
      if (!fin) chk("R12 run ended", 0, 1);
      @(negedge clk);
      post_pulse = int'(done_o) + int'(err_o) + int'(busy_o);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
   end

   initial begin
      clr_model = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; clr_model = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 rst_req", int'(rst_req_o), 1);
      chk("R1 clk_en", int'(clk_en_o), 0);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 pulses", int'(pwr_on_o | pwr_off_o | done_o | err_o | gfx_wr_o | (|clamp_cmd_o)), 0);

      // R2 R5 R7 R8 R10: sweep over every partition
      for (int p = 0; p < N; p++) begin
         logic [N-1:0] exp_vec;
         clear_model();
         run(p, 0);
         exp_vec = (p == GFX) ? '0 : (p == PA) ? N'(1) << PB : (p == PB) ? N'(1) << PA : N'(1) << p;
         chk("R2 done", n_done, 1);
         chk("R2 no error", n_err, 0);
         chk("R2 one pwr_on", n_on, 1);
         chk("R2 clock after power", int'(rise_c > on_c), 1);
         chk("R2 final rst_req", int'(rst_req_o), 0);
         chk("R2 final clk_en", int'(clk_en_o), 1);
         chk("R2 pulse one cycle", post_pulse, 0);
         chk("R7 R8 clamp vector", int'(clamp_seen), int'(exp_vec));
         chk("R10 gfx strobe", n_gfx, (p == GFX) ? 1 : 0);
         chk("R5 settle cycles", clamp_c - rise_c, (1 + SET) * CYC);
         chk("R13 part_o", int'(part_o), p);
      end

      // R3 already powered
      clear_model();
      preset_pwr = N'(1) << 3;
      run(3, 0);
      chk("R3 no pwr_on", n_on, 0);
      chk("R3 done", n_done, 1);
      preset_pwr = '0;

      // R4 boundary: power arrives exactly at the last poll
      clear_model(); pwr_dly = LIM * CYC;
      run(1, 0);
      chk("R4 last poll ok", n_done, 1);
      clear_model(); pwr_dly = LIM * CYC + 1;
      run(1, 0);
      chk("R4 late power code", code_seen, 1);
      // R12 early unwind
      chk("R12 pwr_off", n_off, 1);
      chk("R12 no clock", rise_c, -1);
      chk("R12 rst held", int'(rst_req_o), 1);
      chk("R12 no clamp", n_clamp, 0);
      pwr_dly = 1;

      // R6 clock never acknowledged
      clear_model(); clk_good = 1'b0;
      run(1, 0);
      chk("R6 code", code_seen, 2);
      chk("R12 code2 pwr_off", n_off, 1);
      chk("R12 code2 clock untouched", int'(clk_en_o), 1);
      clk_good = 1'b1;

      // R7 clamp command never completes
      clear_model(); clamp_busy = 1'b1;
      run(4, 0);
      chk("R7 code", code_seen, 3);
      chk("R12 clock off before power off", int'(fall_c >= 0 && fall_c < off_c), 1);
      clamp_busy = 1'b0;

      // R8 status read at own index: partner bit clamped does not matter
      clear_model(); clamped = N'(1) << PB;
      run(PA, 0);
      chk("R8 own index status", n_done, 1);
      // R9 still clamped
      clear_model();
      run(PB, 0);
      chk("R9 code", code_seen, 4);
      chk("R9 swapped bit", int'(clamp_seen), int'(N'(1) << PA));
      chk("R12 code4 clock off", int'(clk_en_o), 0);
      clamped = '0;

      // R11 reset release never seen
      clear_model(); rst_stuck = 1'b1;
      run(6, 0);
      chk("R11 code", code_seen, 5);
      chk("R12 code5 order", int'(fall_c >= 0 && fall_c < off_c), 1);
      chk("R12 code5 one pwr_off", n_off, 1);
      rst_stuck = 1'b0;

      // R13 second start while running
      clear_model();
      run(0, 1);
      chk("R13 single done", n_done, 1);
      chk("R13 target kept", int'(part_o), 0);
      chk("R13 clamp bit kept", int'(clamp_seen), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule